// File: doc/BRIEF.md
# Framed Serial Byte Aligner

This block receives a serial bit stream, one bit per accepted transfer, that carries a repeating frame. Each frame opens with the 8-bit alignment word 47h. A fixed number of payload bytes follows it, and each payload byte is preceded by a single marker bit of value 1. The block starts in a hunting state and watches the stream for the alignment word. Once it finds the word, it locks. While locked it checks the alignment word and every marker bit on each frame, and it turns the payload bits back into bytes.

Each recovered byte leaves through a valid/ready output together with its annotation: a start-of-frame flag and the byte's index within the frame. Data and annotation always travel in the same transfer, so a downstream circuit needs no separate timing strobe to find the payload. The serial input has its own valid/ready handshake. When the output cannot take a finished byte, the input is held off, so no bit is dropped.

Top module: `framed_byte_aligner`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, and the block is hunting.
- R2: While hunting, the last 8 accepted bits are compared with 47h, with the earliest bit as the MSB. A match locks the block, and the next accepted bit is the marker of payload byte 0.
- R3: While locked, each payload byte is a marker bit followed by 8 data bits sent MSB first. After PAYLOAD_BYTES bytes, the next 8 bits are the alignment word of the following frame.
- R4: out_index gives the byte position 0..PAYLOAD_BYTES-1 within the frame. out_sof is high exactly when out_index is 0.
- R5: No byte is output while the block is hunting.
- R6: While out_valid is high and out_ready is low, in_ready is low and out_byte, out_sof and out_index stay unchanged.
- R7: A byte appears on out_valid in the cycle after its last data bit is accepted. in_ready is high whenever out_valid is low or out_ready is high.
- R8: A frame is bad if any bit of its alignment word or any of its marker bits is wrong. After BAD_LIMIT consecutive bad frames, the block emits the last byte of the final bad frame and then returns to hunting. A good frame clears the count.
- R9: While fewer than BAD_LIMIT consecutive bad frames have been seen, the block stays locked and still outputs every payload byte of a bad frame.
- R10: A cycle with in_valid low accepts no bit and leaves the frame position unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A serial bit is offered |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | The block can take a bit this cycle |
| out_valid | output | 1 | A recovered payload byte is held |
| out_ready | input | 1 | Downstream takes the byte |
| out_byte | output | 8 | Recovered payload byte |
| out_sof | output | 1 | Byte is the first of its frame |
| out_index | output | IDX_W | Byte position within the frame |

## Verification
The hardest condition to reach from the ports is loss of lock. It needs BAD_LIMIT frames in a row that are bad, and it must not be undone by one good frame in between. To check that the count clears, the stimulus first mixes corrupted alignment words and corrupted marker bits with good frames in between. It then sends an unbroken run of bad frames whose last byte is all ones, so that the search window cannot re-lock on payload bits. Ones-only idle traffic follows, which proves that nothing is output until a real alignment word arrives. The stimulus also applies random output stalls and random gaps on the input. This is to show that input stalls and idle cycles never shift the frame position.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  typedef enum logic [1:0] {
    PH_HUNT = 2'd0,
    PH_SYNC = 2'd1,
    PH_MARK = 2'd2,
    PH_DATA = 2'd3
  } phase_e;

  // expected bit of the alignment word at position k (k = 0 is sent first)
  function automatic logic sync_bit_at(input logic [7:0] word, input logic [2:0] k);
    return word[3'd7 - k];
  endfunction

  // one more bit shifted into a window, newest bit in the LSB
  function automatic logic [7:0] window_shift(input logic [7:0] win, input logic b);
    return {win[6:0], b};
  endfunction

  // width for an index counting 0..n-1
  function automatic int unsigned index_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sync_window.sv
module sync_window
  import aligner_pkg::*;
#(
  parameter logic [7:0] SYNC_WORD = 8'h47
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  output logic match_next
);

  logic [7:0] win_q;
  logic [7:0] win_d;

  assign win_d      = window_shift(win_q, bit_in);
  assign match_next = (win_d == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q <= 8'hFF;
    end else if (shift_en) begin
      win_q <= win_d;
    end
  end

  // R10: the window only moves on an accepted bit
  assert_window_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(win_q));

endmodule

// File: rtl/frame_tracker.sv
module frame_tracker
  import aligner_pkg::*;
#(
  parameter int unsigned PAYLOAD_BYTES = 4,
  parameter int unsigned BAD_LIMIT     = 3,
  parameter logic [7:0]  SYNC_WORD     = 8'h47,
  localparam int unsigned IDX_W        = index_width(PAYLOAD_BYTES),
  localparam int unsigned CNT_W        = $clog2(BAD_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             bit_in,
  input  logic             window_match,
  output logic             locked,
  output logic             data_shift,
  output logic             byte_done,
  output logic [IDX_W-1:0] byte_idx
);

  phase_e           phase_q;
  logic [2:0]       bit_cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             frame_bad_q;
  logic [CNT_W-1:0] bad_cnt_q;

  // named internal events
  logic ev_lock;
  logic ev_mismatch;
  logic ev_frame_end;
  logic ev_drop;
  logic last_byte;
  logic last_bit;

  assign last_byte    = (idx_q == IDX_W'(PAYLOAD_BYTES - 1));
  assign last_bit     = (bit_cnt_q == 3'd7);
  assign ev_lock      = accept && (phase_q == PH_HUNT) && window_match;
  assign ev_mismatch  = accept &&
                        (((phase_q == PH_SYNC) && (bit_in != sync_bit_at(SYNC_WORD, bit_cnt_q))) ||
                         ((phase_q == PH_MARK) && !bit_in));
  assign ev_frame_end = accept && (phase_q == PH_DATA) && last_bit && last_byte;
  assign ev_drop      = ev_frame_end && frame_bad_q &&
                        (bad_cnt_q == CNT_W'(BAD_LIMIT - 1));

  assign locked     = (phase_q != PH_HUNT);
  assign data_shift = accept && (phase_q == PH_DATA);
  assign byte_done  = data_shift && last_bit;
  assign byte_idx   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= PH_HUNT;
      bit_cnt_q   <= '0;
      idx_q       <= '0;
      frame_bad_q <= 1'b0;
      bad_cnt_q   <= '0;
    end else if (accept) begin
      if (ev_mismatch) frame_bad_q <= 1'b1;
      unique case (phase_q)
        PH_HUNT: begin
          if (window_match) begin
            phase_q     <= PH_MARK;
            bit_cnt_q   <= '0;
            idx_q       <= '0;
            frame_bad_q <= 1'b0;
            bad_cnt_q   <= '0;
          end
        end
        PH_SYNC: begin
          if (last_bit) begin
            phase_q   <= PH_MARK;
            bit_cnt_q <= '0;
            idx_q     <= '0;
          end else begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end
        end
        PH_MARK: begin
          phase_q   <= PH_DATA;
          bit_cnt_q <= '0;
        end
        PH_DATA: begin
          if (!last_bit) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end else if (!last_byte) begin
            bit_cnt_q <= '0;
            idx_q     <= idx_q + IDX_W'(1);
            phase_q   <= PH_MARK;
          end else begin
            bit_cnt_q   <= '0;
            frame_bad_q <= 1'b0;
            if (ev_drop) begin
              phase_q   <= PH_HUNT;
              bad_cnt_q <= '0;
            end else begin
              phase_q   <= PH_SYNC;
              bad_cnt_q <= frame_bad_q ? bad_cnt_q + CNT_W'(1) : '0;
            end
          end
        end
        default: phase_q <= PH_HUNT;
      endcase
    end
  end

  // R2: a window match while hunting leads to the marker of byte 0
  assert_lock_to_marker_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_lock |=> (phase_q == PH_MARK) && (idx_q == '0));

  // R3: a frame that does not drop lock continues with the alignment word
  assert_frame_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && !ev_drop) |=> (phase_q == PH_SYNC) && (bit_cnt_q == 3'd0));

  // R8: the bad-frame count never reaches the limit while locked
  assert_bad_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cnt_q < CNT_W'(BAD_LIMIT));

  // R8: reaching the limit returns to hunting
  assert_drop_to_hunt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> (phase_q == PH_HUNT));

  // R9: a bad frame below the limit keeps the lock
  assert_keep_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && frame_bad_q && !ev_drop) |=> locked);

  // R10: no accepted bit, no movement in the frame position
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(phase_q) && $stable(bit_cnt_q) && $stable(idx_q));

endmodule

// File: rtl/byte_out_stage.sv
module byte_out_stage
  import aligner_pkg::*;
#(
  parameter int unsigned PAYLOAD_BYTES = 4,
  localparam int unsigned IDX_W        = index_width(PAYLOAD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             bit_in,
  input  logic             load,
  input  logic [IDX_W-1:0] idx_in,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_byte,
  output logic             out_sof,
  output logic [IDX_W-1:0] out_index,
  output logic             room
);

  logic [6:0] sr_q;

  assign room = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q      <= '0;
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_sof   <= 1'b0;
      out_index <= '0;
    end else begin
      if (shift_en) sr_q <= {sr_q[5:0], bit_in};
      if (load) begin
        out_valid <= 1'b1;
        out_byte  <= {sr_q, bit_in};
        out_index <= idx_in;
        out_sof   <= (idx_in == '0);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R6: a held byte does not change until it is taken
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_byte) &&
                                  $stable(out_index) && $stable(out_sof));

  // R6: a finished byte never lands on a held one
  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !load);

  // R4: index stays inside the frame, flag follows index 0
  assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_index <= IDX_W'(PAYLOAD_BYTES - 1)) && (out_sof == (out_index == '0)));

endmodule

// File: rtl/framed_byte_aligner.sv
module framed_byte_aligner
  import aligner_pkg::*;
#(
  parameter int unsigned PAYLOAD_BYTES = 4,
  parameter int unsigned BAD_LIMIT     = 3,
  parameter logic [7:0]  SYNC_WORD     = 8'h47,
  localparam int unsigned IDX_W        = index_width(PAYLOAD_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_bit,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_sof,
  output logic [IDX_W-1:0] out_index
);

  logic             accept;
  logic             window_match;
  logic             locked;
  logic             data_shift;
  logic             byte_done;
  logic [IDX_W-1:0] byte_idx;
  logic             room;

  assign in_ready = room;
  assign accept   = in_valid && room;

  sync_window #(
    .SYNC_WORD (SYNC_WORD)
  ) i_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (accept),
    .bit_in     (in_bit),
    .match_next (window_match)
  );

  frame_tracker #(
    .PAYLOAD_BYTES (PAYLOAD_BYTES),
    .BAD_LIMIT     (BAD_LIMIT),
    .SYNC_WORD     (SYNC_WORD)
  ) i_tracker (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .bit_in       (in_bit),
    .window_match (window_match),
    .locked       (locked),
    .data_shift   (data_shift),
    .byte_done    (byte_done),
    .byte_idx     (byte_idx)
  );

  byte_out_stage #(
    .PAYLOAD_BYTES (PAYLOAD_BYTES)
  ) i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (data_shift),
    .bit_in    (in_bit),
    .load      (byte_done),
    .idx_in    (byte_idx),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_sof   (out_sof),
    .out_index (out_index),
    .room      (room)
  );

  // R5: a new byte only appears if the block was locked on the edge before
  assert_no_hunt_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(locked));

  // R7: a byte shows up right after its last data bit is taken
  assert_byte_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> out_valid && (out_index == $past(byte_idx)));

  // R6: input is held off while a byte waits
  assert_input_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

// File: tb/test_framed_byte_aligner.sv
module test_framed_byte_aligner;

  localparam int P     = 4;
  localparam int LIMIT = 3;
  localparam int IW    = 2;
  localparam int FRAME = 8 + 9 * P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_bit = 1'b0;
  logic          in_ready;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [7:0]    out_byte;
  logic          out_sof;
  logic [IW-1:0] out_index;

  always #5 clk = ~clk;

  framed_byte_aligner #(.PAYLOAD_BYTES(P), .BAD_LIMIT(LIMIT), .SYNC_WORD(8'h47)) i_framed_byte_aligner (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_sof(out_sof), .out_index(out_index)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rmode  = 0;
  int gap_max = 0;
  int got_cnt = 0;
  int sof_cnt = 0;
  logic [7:0] first_got;
  bit first_seen = 0;

  // behavioural reference: position in frame as a plain integer
  bit         m_locked;
  int         m_pos;
  logic [7:0] m_win;
  bit         m_bad;
  int         m_badcnt;
  logic [7:0] m_data;
  bit         m_valid;
  logic [7:0] m_byte;
  int         m_idx;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_locked = 0; m_pos = 0; m_win = 8'hFF; m_bad = 0; m_badcnt = 0;
      m_data = 0; m_valid = 0; m_byte = 0; m_idx = 0;
    end else begin
      bit acc;
      if (out_valid && out_ready) begin
        got_cnt++;
        if (out_sof) sof_cnt++;
        if (!first_seen) begin first_seen = 1; first_got = out_byte; end
      end
      acc = in_valid && (!m_valid || out_ready);
      if (m_valid && out_ready) m_valid = 0;
      if (acc) begin
        m_win = {m_win[6:0], in_bit};
        if (!m_locked) begin
          if (m_win == 8'h47) begin
            m_locked = 1; m_pos = 8; m_bad = 0; m_badcnt = 0;
          end
        end else begin
          if (m_pos < 8) begin
            if (in_bit != ((8'h47 >> (7 - m_pos)) & 1)) m_bad = 1;
          end else begin
            int off;
            off = (m_pos - 8) % 9;
            if (off == 0) begin
              if (in_bit != 1'b1) m_bad = 1;
            end else begin
              m_data = {m_data[6:0], in_bit};
              if (off == 8) begin
                m_valid = 1; m_byte = m_data; m_idx = (m_pos - 8) / 9;
              end
            end
          end
          m_pos++;
          if (m_pos == FRAME) begin
            m_pos = 0;
            if (m_bad) begin
              m_badcnt++;
              if (m_badcnt == LIMIT) begin m_locked = 0; m_badcnt = 0; end
            end else m_badcnt = 0;
            m_bad = 0;
          end
        end
      end
    end
  end

  // compare every cycle, away from the edge
  logic          p_valid = 0, p_ready = 0, p_sof = 0;
  logic [7:0]    p_byte = 0;
  logic [IW-1:0] p_idx = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      check(in_ready == (!m_valid || out_ready), "R7 in_ready", in_ready, (!m_valid || out_ready));
      check(out_valid == m_valid, "R5 out_valid", out_valid, m_valid);
      if (m_valid) begin
        check(out_byte == m_byte, "R3 out_byte", out_byte, m_byte);
        check(out_index == IW'(m_idx), "R4 out_index", out_index, m_idx);
        check(out_sof == (m_idx == 0), "R4 out_sof", out_sof, (m_idx == 0));
      end
      if (p_valid && !p_ready) begin
        check(out_valid && out_byte == p_byte && out_index == p_idx && out_sof == p_sof,
              "R6 held byte", out_byte, p_byte);
      end
      p_valid = out_valid; p_ready = out_ready; p_byte = out_byte;
      p_idx = out_index; p_sof = out_sof;
    end
  end

  always @(posedge clk) begin
    #2;
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = $urandom_range(0, 1) == 1;
      default: out_ready = $urandom_range(0, 3) == 0;
    endcase
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog R7 actual=%0d expected<150000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic send_bit(input logic b);
    bit acc;
    in_valid = 1'b1;
    in_bit   = b;
    forever begin
      @(negedge clk);
      acc = in_ready;
      @(posedge clk); #2;
      if (acc) break;
    end
    in_valid = 1'b0;
    if (gap_max > 0) begin
      int g;
      g = $urandom_range(0, gap_max);
      for (int i = 0; i < g; i++) begin
        @(posedge clk); #2;
      end
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_frame(input logic [7:0] sync, input logic mark1, input bit last_ff);
    send_byte(sync);
    for (int b = 0; b < P; b++) begin
      logic [7:0] v;
      v = $urandom_range(0, 255);
      if (last_ff && b == P - 1) v = 8'hFF;
      send_bit((b == 1) ? mark1 : 1'b1);
      send_byte(v);
    end
  endtask

  task automatic drain();
    rmode = 0;
    repeat (20) begin @(posedge clk); #2; end
  endtask

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #2;

    // R5: ones only, never a lock
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    drain();
    check(got_cnt == 0, "R5 bytes while hunting", got_cnt, 0);

    // R2 R3 R4: clean frames, no stalls
    base = got_cnt;
    first_seen = 0;
    for (int f = 0; f < 3; f++) send_frame(8'h47, 1'b1, 0);
    drain();
    check(got_cnt - base == 3 * P, "R3 bytes for three frames", got_cnt - base, 3 * P);
    check(sof_cnt == 3, "R4 start-of-frame count", sof_cnt, 3);
    check(first_seen && first_got !== 8'hxx, "R2 first byte after lock", first_seen, 1);

    // R6 R7: random output stalls with input gaps
    base = got_cnt;
    gap_max = 2;
    rmode = 1;
    for (int f = 0; f < 4; f++) send_frame(8'h47, 1'b1, 0);
    drain();
    check(got_cnt - base == 4 * P, "R7 bytes under back-pressure", got_cnt - base, 4 * P);

    // R10: long idle gaps and rare ready
    base = got_cnt;
    gap_max = 6;
    rmode = 2;
    for (int f = 0; f < 2; f++) send_frame(8'h47, 1'b1, 0);
    drain();
    check(got_cnt - base == 2 * P, "R10 bytes with idle gaps", got_cnt - base, 2 * P);

    // R9: bad frames below the limit keep lock and still deliver
    base = got_cnt;
    gap_max = 1;
    send_frame(8'h46, 1'b1, 0);
    send_frame(8'h46, 1'b1, 0);
    send_frame(8'h47, 1'b1, 0);
    send_frame(8'h47, 1'b0, 0);
    send_frame(8'h47, 1'b0, 0);
    send_frame(8'h47, 1'b1, 0);
    drain();
    check(got_cnt - base == 6 * P, "R9 bytes across bad frames", got_cnt - base, 6 * P);

    // R8: limit reached, then hunting ignores ones
    base = got_cnt;
    for (int f = 0; f < LIMIT; f++) send_frame(8'h46, 1'b1, 1);
    for (int i = 0; i < 40; i++) send_bit(1'b1);
    drain();
    check(got_cnt - base == LIMIT * P, "R8 output stops after drop", got_cnt - base, LIMIT * P);

    // R2: a fresh alignment word locks again
    base = got_cnt;
    send_frame(8'h47, 1'b1, 0);
    drain();
    check(got_cnt - base == P, "R2 relock delivers one frame", got_cnt - base, P);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule